// File: doc/BRIEF.md
# Serial Comma Aligner with Internal Loopback

This block sits on the receive side of a ten-bit serial link. It takes one recovered bit per clock, packs the bits into ten-bit words and presents each finished word on a parallel bus with a one-cycle strobe. When alignment is enabled it watches for a seven-bit comma of either polarity. When it finds one, it shifts the word boundary so that the comma opens the next word, and it flags that word. When alignment is disabled the boundary stays where it is and commas are ignored.

Every strobe comes with exactly one of two phase enables, and the two take turns. A downstream stage can treat them as two opposite-phase clocks running at half the word rate. The same block also serializes the local transmit word, least significant bit first. A loopback control sends each transmit word straight to the receive bus and parks the serial transmit line at logic one.

Top module: `comma_word_aligner`

## Requirements
- R1: While reset is asserted, rx_word is zero; rx_comma, word_stb, phase_a and phase_b are low; tx_serial is high.
- R2: After reset, with align_en low, the first received bit is bit 0 of the first word. A word is completed every ten bits, and word_stb pulses for one cycle in the cycle after the clock edge that captured the tenth bit.
- R3: While align_en is low, a comma in the stream does not raise rx_comma and does not move the word boundary.
- R4: While align_en is high, a comma in either polarity moves the word boundary. In arrival order a comma is 0011111 or 1100000, which is bits[6:0] = 7'b1111100 or 7'b0000011 of the output word. The word that holds the comma is presented with the comma in bits 0 to 6.
- R5: rx_comma is high only together with word_stb, and only for the word that carries a comma that caused alignment.
- R6: If the comma's seventh bit arrives in the clock cycle that would have completed a word, the partial word is dropped and no strobe follows that edge.
- R7: After realignment, words continue every ten bits from the new boundary. No expected word is lost or duplicated.
- R8: Each strobe comes with exactly one phase enable. The first strobe after reset carries phase_a and later strobes alternate. Without a strobe both phases are low.
- R9: With loop_en high, tx_serial stays high. The tx_word present at each transmit load edge appears on rx_word with a strobe one cycle later, and these strobes are exactly ten cycles apart.
- R10: With loop_en low, tx_word is loaded at the first edge after reset and every ten edges after that, and it is shifted out on tx_serial least significant bit first, one bit per edge.
- R11: With loop_en high, the serial receive input has no effect on the outputs, and rx_comma stays low even when commas arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Recovered serial receive bit |
| align_en | input | 1 | Enables comma search and boundary realignment |
| loop_en | input | 1 | Routes transmit words to the receive bus; parks tx_serial high |
| tx_word | input | 10 | Parallel transmit word |
| tx_serial | output | 1 | Serial transmit bit, LSB first |
| rx_word | output | 10 | Received parallel word, held between strobes |
| rx_comma | output | 1 | The presented word carries an aligned comma |
| word_stb | output | 1 | One-cycle pulse when a new word is presented |
| phase_a | output | 1 | Strobe qualifier, even-numbered words |
| phase_b | output | 1 | Strobe qualifier, odd-numbered words |

## Verification
On every cycle the assertions check the phase pairing and alternation, that a comma flag never appears without a strobe, that loopback echoes the transmit word and never flags a comma, and that a realignment edge is never followed by a strobe. Only the bench scenarios can show where the boundary actually lands. They confirm that a misaligned comma of each polarity reshapes the following words, that a comma with alignment disabled leaves the boundary unchanged, that the colliding partial word is dropped, and that the serial transmit bit order is correct. A scoreboard fed by the stimulus tasks supplies every expected word and flag.

// File: rtl/cwa_pkg.sv
package cwa_pkg;

  typedef enum logic {
    SRC_SERIAL = 1'b0,
    SRC_LOOP   = 1'b1
  } src_sel_e;

  // Modulo step of a position counter that wraps after 'last'.
  function automatic int unsigned wrap_step(input int unsigned v, input int unsigned last);
    return (v >= last) ? 0 : v + 1;
  endfunction

  // Position the framer resumes at after a comma ends on the incoming bit.
  function automatic int unsigned resume_pos(input int unsigned comma_len);
    return comma_len;
  endfunction

endpackage

// File: rtl/cwa_comma_detect.sv
module cwa_comma_detect #(
  parameter int                 COMMA_W   = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
  input  logic [COMMA_W-1:0] win,
  output logic               hit
);
  logic [1:0] pol_hit;

  // One comparator per comma polarity.
  for (genvar p = 0; p < 2; p++) begin : g_pol
    localparam logic [COMMA_W-1:0] REF = (p == 0) ? COMMA_PAT : ~COMMA_PAT;
    assign pol_hit[p] = (win == REF);
  end

  assign hit = |pol_hit;
endmodule

// File: rtl/cwa_framer.sv
module cwa_framer #(
  parameter int                 WORD_W    = 10,
  parameter int                 COMMA_W   = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  input  logic              align_en,
  output logic              emit,
  output logic [WORD_W-1:0] word_now,
  output logic              flag_now,
  output logic              realign
);
  import cwa_pkg::*;

  localparam int POS_W = $clog2(WORD_W);
  localparam logic [POS_W-1:0] POS_LAST   = POS_W'(WORD_W - 1);
  localparam logic [POS_W-1:0] POS_RESUME = POS_W'(resume_pos(COMMA_W));

  logic [WORD_W-2:0] hist;   // earlier bits of the word, oldest at bit 0
  logic [POS_W-1:0]  pos;    // word index the incoming bit lands on
  logic              pend;   // current word began with an aligned comma
  logic              hit;

  // Incoming bit sits on top of the history: a complete word on the last index.
  assign word_now = {rx_bit, hist};

  cwa_comma_detect #(
    .COMMA_W  (COMMA_W),
    .COMMA_PAT(COMMA_PAT)
  ) u_det (
    .win(word_now[WORD_W-1 -: COMMA_W]),
    .hit(hit)
  );

  assign realign  = align_en & hit;
  assign emit     = (pos == POS_LAST) & ~realign;
  assign flag_now = pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      pos  <= '0;
      pend <= 1'b0;
    end else begin
      hist <= word_now[WORD_W-1:1];
      if (realign) begin
        pos  <= POS_RESUME;
        pend <= 1'b1;
      end else begin
        pos <= POS_W'(wrap_step(int'(pos), WORD_W - 1));
        if (emit) pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cwa_tx_ser.sv
module cwa_tx_ser #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_en,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_load,
  output logic              tx_serial
);
  import cwa_pkg::*;

  localparam int CNT_W = $clog2(WORD_W);

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;

  assign tx_load = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '1;
    end else begin
      cnt <= CNT_W'(wrap_step(int'(cnt), WORD_W - 1));
      if (tx_load) shreg <= tx_word;
      else         shreg <= {1'b1, shreg[WORD_W-1:1]};
    end
  end

  assign tx_serial = loop_en | shreg[0];
endmodule

// File: rtl/cwa_out_stage.sv
module cwa_out_stage #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_en,
  input  logic              rx_emit,
  input  logic [WORD_W-1:0] rx_word_in,
  input  logic              rx_flag,
  input  logic              tx_load,
  input  logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_comma,
  output logic              word_stb,
  output logic              phase_a,
  output logic              phase_b
);
  import cwa_pkg::*;

  src_sel_e          src;
  logic              sel_stb;
  logic              sel_flag;
  logic [WORD_W-1:0] sel_word;
  logic              tog;

  assign src = loop_en ? SRC_LOOP : SRC_SERIAL;

  always_comb begin
    case (src)
      SRC_LOOP: begin
        sel_stb  = tx_load;
        sel_word = tx_word;
        sel_flag = 1'b0;
      end
      default: begin
        sel_stb  = rx_emit;
        sel_word = rx_word_in;
        sel_flag = rx_flag;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word  <= '0;
      rx_comma <= 1'b0;
      word_stb <= 1'b0;
      phase_a  <= 1'b0;
      phase_b  <= 1'b0;
      tog      <= 1'b0;
    end else begin
      word_stb <= sel_stb;
      rx_comma <= sel_stb & sel_flag;
      phase_a  <= sel_stb & ~tog;
      phase_b  <= sel_stb & tog;
      if (sel_stb) begin
        rx_word <= sel_word;
        tog     <= ~tog;
      end
    end
  end
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
  parameter int                 WORD_W    = 10,
  parameter int                 COMMA_W   = 7,
  parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  input  logic              align_en,
  input  logic              loop_en,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_serial,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_comma,
  output logic              word_stb,
  output logic              phase_a,
  output logic              phase_b
);
  // Named internal events, visible to the bound checker.
  logic              rx_emit;
  logic [WORD_W-1:0] rx_word_now;
  logic              rx_flag;
  logic              realign_evt;
  logic              tx_load;

  cwa_framer #(
    .WORD_W   (WORD_W),
    .COMMA_W  (COMMA_W),
    .COMMA_PAT(COMMA_PAT)
  ) u_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_bit  (rx_bit),
    .align_en(align_en),
    .emit    (rx_emit),
    .word_now(rx_word_now),
    .flag_now(rx_flag),
    .realign (realign_evt)
  );

  cwa_tx_ser #(.WORD_W(WORD_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .loop_en  (loop_en),
    .tx_word  (tx_word),
    .tx_load  (tx_load),
    .tx_serial(tx_serial)
  );

  cwa_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .loop_en   (loop_en),
    .rx_emit   (rx_emit),
    .rx_word_in(rx_word_now),
    .rx_flag   (rx_flag),
    .tx_load   (tx_load),
    .tx_word   (tx_word),
    .rx_word   (rx_word),
    .rx_comma  (rx_comma),
    .word_stb  (word_stb),
    .phase_a   (phase_a),
    .phase_b   (phase_b)
  );
endmodule

// File: rtl/comma_word_aligner_chk.sv
module comma_word_aligner_chk #(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              loop_en,
  input logic [WORD_W-1:0] tx_word,
  input logic [WORD_W-1:0] rx_word,
  input logic              rx_comma,
  input logic              word_stb,
  input logic              phase_a,
  input logic              phase_b,
  input logic              realign_evt
);
  logic last_ph;
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_ph <= 1'b0;
      seen    <= 1'b0;
    end else if (word_stb) begin
      last_ph <= phase_b;
      seen    <= 1'b1;
    end
  end

  // R8
  stb_one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> $onehot({phase_a, phase_b}));

  // R8
  phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_stb |-> (!phase_a && !phase_b));

  // R8
  phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && seen) |-> (phase_b != last_ph));

  // R5
  comma_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_comma |-> word_stb);

  // R9
  loop_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && $past(loop_en)) |-> (rx_word == $past(tx_word)));

  // R11
  loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(loop_en) |-> !rx_comma);

  // R6
  realign_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (realign_evt && !loop_en) |=> !word_stb);
endmodule

bind comma_word_aligner comma_word_aligner_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .loop_en    (loop_en),
  .tx_word    (tx_word),
  .rx_word    (rx_word),
  .rx_comma   (rx_comma),
  .word_stb   (word_stb),
  .phase_a    (phase_a),
  .phase_b    (phase_b),
  .realign_evt(realign_evt)
);

// File: tb/comma_word_aligner_test.sv
module comma_word_aligner_test;
  localparam int W = 10;
  localparam logic [W-1:0] TX_FIXED = 10'h2A5;
  localparam logic [W-1:0] K_POS    = 10'b0101111100;  // arrival 0011111 010
  localparam logic [W-1:0] K_NEG    = 10'b1010000011;  // arrival 1100000 101
  localparam logic [W-1:0] D_ALT    = 10'h155;
  localparam logic [W-1:0] D_MIX    = 10'h0F3;

  logic clk = 1'b0, rst_n = 1'b0, rx_bit = 1'b0, align_en = 1'b0, loop_en = 1'b0;
  logic [W-1:0] tx_word = TX_FIXED;
  logic tx_serial, rx_comma, word_stb, phase_a, phase_b;
  logic [W-1:0] rx_word;

  comma_word_aligner uut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .align_en(align_en),
    .loop_en(loop_en), .tx_word(tx_word), .tx_serial(tx_serial),
    .rx_word(rx_word), .rx_comma(rx_comma), .word_stb(word_stb),
    .phase_a(phase_a), .phase_b(phase_b)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [W-1:0] w;
    logic         f;
    string        tag;
  } item_t;

  item_t q[$];
  item_t it;
  int checks = 0, errors = 0, edges = 0, last_loop_edge = -1;
  logic exp_ph = 1'b0;
  string cur_tag = "R2";
  logic [W-1:0] acc = '0;
  int accn = 0;
  logic pend = 1'b0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_if_full();
    if (accn == W) begin
      q.push_back('{w: acc, f: pend, tag: cur_tag});
      pend = 1'b0;
      accn = 0;
    end
  endtask

  // Driver: put one bit on the line, record it in the expected framing.
  task automatic drive_bit(input logic b);
    rx_bit    = b;
    acc[accn] = b;
    accn++;
    push_if_full();
    @(negedge clk);
  endtask

  task automatic send_word(input logic [W-1:0] w);
    for (int i = 0; i < W; i++) drive_bit(w[i]);
  endtask

  // Comma word sent with alignment on: boundary jumps at the seventh bit.
  task automatic send_comma(input logic [W-1:0] w);
    for (int i = 0; i < 6; i++) drive_bit(w[i]);
    rx_bit   = w[6];
    acc      = '0;
    acc[6:0] = w[6:0];
    accn     = 7;
    pend     = 1'b1;
    @(negedge clk);
    for (int i = 7; i < W; i++) drive_bit(w[i]);
  endtask

  // Monitor / scoreboard
  always @(posedge clk) begin
    if (rst_n) edges++;
    #1;
    if (rst_n && !done) begin
      if (loop_en) begin
        check(tx_serial == 1'b1, "R9", tx_serial, 1);
        check(!rx_comma, "R11", rx_comma, 0);
        if (word_stb) begin
          check(rx_word == tx_word, "R9", rx_word, tx_word);
          if (last_loop_edge >= 0)
            check(edges - last_loop_edge == W, "R9", edges - last_loop_edge, W);
          last_loop_edge = edges;
        end
      end else begin
        check(tx_serial == TX_FIXED[(edges - 1) % W], "R10", tx_serial, TX_FIXED[(edges - 1) % W]);
        if (word_stb) begin
          if (q.size() == 0) begin
            check(1'b0, "R7", rx_word, 0);
          end else begin
            it = q.pop_front();
            check(rx_word == it.w, it.tag, rx_word, it.w);
            check(rx_comma == it.f, "R5", rx_comma, it.f);
          end
        end else begin
          check(!rx_comma, "R5", rx_comma, 0);
        end
      end
      if (word_stb) begin
        check(phase_a == ~exp_ph && phase_b == exp_ph, "R8", {phase_a, phase_b}, {~exp_ph, exp_ph});
        exp_ph = ~exp_ph;
      end else begin
        check(!phase_a && !phase_b, "R8", {phase_a, phase_b}, 0);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(rx_word == '0, "R1", rx_word, 0);
    check(!rx_comma && !word_stb, "R1", {rx_comma, word_stb}, 0);
    check(!phase_a && !phase_b, "R1", {phase_a, phase_b}, 0);
    check(tx_serial == 1'b1, "R1", tx_serial, 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: plain framing from offset 0
    cur_tag = "R2";
    send_word(D_ALT);
    send_word(D_MIX);

    // R3: misaligned comma with alignment disabled keeps the boundary
    cur_tag = "R3";
    drive_bit(1'b1); drive_bit(1'b0); drive_bit(1'b1);
    for (int i = 0; i < W; i++) drive_bit(K_POS[i]);
    for (int i = 0; i < 7; i++) drive_bit(i[0]);

    // R6: comma completes on the edge that would finish a word
    align_en = 1'b1;
    cur_tag  = "R6";
    for (int i = 0; i < 13; i++) drive_bit(~i[0]);
    send_comma(K_POS);
    cur_tag = "R7";
    send_word(D_ALT);
    send_word(D_ALT);

    // R4: negative comma four bits off, then an aligned positive comma
    cur_tag = "R4";
    drive_bit(1'b1); drive_bit(1'b0); drive_bit(1'b1); drive_bit(1'b0);
    send_comma(K_NEG);
    cur_tag = "R7";
    send_word(D_ALT);
    cur_tag = "R4";
    send_comma(K_POS);
    cur_tag = "R7";
    send_word(D_ALT);

    align_en = 1'b0;
    cur_tag  = "R2";
    send_word(D_MIX);

    // R9 / R11: loopback, with commas on the serial input
    loop_en  = 1'b1;
    align_en = 1'b1;
    for (int i = 0; i < 45; i++) begin
      tx_word = W'(i * 37 + 5);
      rx_bit  = K_POS[i % W];
      @(negedge clk);
    end

    done = 1'b1;
    check(q.size() == 0, "R7", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule